// File: doc/BRIEF.md
# Serial Dual Wiper Setting Interface

This block is the digital control front end of a two-channel digital potentiometer. A host selects the device with a chip-select line and clocks a 17-bit frame into it, one bit per serial clock rise. The frame carries an 8-bit tap position for each of the two wipers and a single stack-select flag. The wiper and stack outputs stay unchanged while a frame is being shifted. They take the new contents only when chip select falls.

While the device is idle, its shift register is refilled from the settings in force. The next transaction therefore shifts the old settings out on the cascade output, and a host reads the device back by returning that pin to itself. When several devices are chained, the cascade output feeds the next device's data input. Every bit that enters one device leaves it seventeen serial clocks later. The serial pins are asynchronous to the block clock and pass through synchronizers before the rising edges are detected.

Top module: `pot3w_if`

## Requirements
- R1: After reset, both wiper outputs read 0x80, and both stackSel and casOut read 0.
- R2: A frame is sent in this order: first the stack-select bit, then the 8 bits of wiper 1 starting with its MSB, then the 8 bits of wiper 0 starting with its MSB. After a 17-bit frame and a fall of csIn, the outputs show those three fields.
- R3: wiper0, wiper1 and stackSel change only after a falling edge of csIn. They keep their values while bits are being shifted in.
- R4: Serial clock edges and data bits that arrive while csIn is low do not affect the outputs. They also do not affect the bits the next transaction shifts out.
- R5: Readback works as follows. During a transaction, casOut shows the old settings in frame order. Before the first serial clock rise, casOut already shows the old stack bit, and it moves on by one bit after each rise.
- R6: When more than 17 bits are sent in one transaction, the last 17 are kept. Each bit sent appears on casOut 17 serial clocks after it entered.
- R7: A csIn pulse with no serial clock rises leaves every setting unchanged.
- R8: casOut is held at 0 while csIn is low.
- R9: A frame shorter than 17 bits still commits on the fall of csIn. The committed frame is the old frame advanced by the number of bits sent, with the new bits at its tail end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Serial chip select, active high |
| sclkIn | input | 1 | Serial clock; data is taken on its rise |
| sdIn | input | 1 | Serial data in |
| wiper0 | output | 8 | Tap position of wiper 0 |
| wiper1 | output | 8 | Tap position of wiper 1 |
| stackSel | output | 1 | Stack-select setting |
| casOut | output | 1 | Cascade / readback data out |

## Verification
The hardest state to reach is a transaction with an unusual number of serial clocks. This covers a frame longer than 17 bits, a frame of only a few bits, and a select pulse with no clocks at all. In each of these cases the committed value depends on old register contents that the ports never show directly. The bench models the register as a queue of bits in frame order, refilled from the settings at every select rise. It drives 34-bit, 5-bit and 0-bit transactions and compares every casOut bit and every committed field against that queue. Idle serial clock activity is checked through the readback of the following transaction.

// File: rtl/pot3w_pkg.sv
package pot3w_pkg;
  typedef struct packed {
    logic shift;     // take one serial bit
    logic load;      // refill register from settings
    logic commit;    // copy register into settings
    logic csActive;  // synchronized chip select
  } ctlStrb_t;
endpackage

// File: rtl/pot3w_ctrl.sv
module pot3w_ctrl
  import pot3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csIn,
  input  logic     sclkIn,
  input  logic     sdIn,
  output ctlStrb_t strb,
  output logic     dataBit
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] csSync, clkSync, dSync;
  logic csPrev, clkPrev;
  logic csNow, clkNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= '0;
      clkSync <= '0;
      dSync   <= '0;
      csPrev  <= 1'b0;
      clkPrev <= 1'b0;
    end else begin
      csSync  <= {csSync[SYNC_STAGES-2:0], csIn};
      clkSync <= {clkSync[SYNC_STAGES-2:0], sclkIn};
      dSync   <= {dSync[SYNC_STAGES-2:0], sdIn};
      csPrev  <= csSync[TOP];
      clkPrev <= clkSync[TOP];
    end
  end

  assign csNow   = csSync[TOP];
  assign clkNow  = clkSync[TOP];
  assign dataBit = dSync[TOP];

  always_comb begin
    strb.csActive = csNow;
    strb.shift    = csNow && clkNow && !clkPrev;
    strb.commit   = !csNow && csPrev;
    strb.load     = !csNow && !strb.commit;
  end

  // R3
  commit_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit);

  // R4
  load_excludes_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.shift));
endmodule

// File: rtl/pot3w_dpath.sv
module pot3w_dpath
  import pot3w_pkg::*;
#(
  parameter int             WIPER_W   = 8,
  parameter logic [WIPER_W-1:0] RESET_POS = 8'h80
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strb,
  input  logic               dataBit,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic               stackSel,
  output logic               casOut
);
  localparam int FW = 2 * WIPER_W + 1;

  function automatic logic [FW-1:0] packFrame(logic [WIPER_W-1:0] w0,
                                               logic [WIPER_W-1:0] w1,
                                               logic stk);
    logic [FW-1:0] f;
    f[0] = stk;
    for (int k = 0; k < WIPER_W; k++) begin
      f[1 + k]           = w1[WIPER_W-1-k];
      f[WIPER_W + 1 + k] = w0[WIPER_W-1-k];
    end
    return f;
  endfunction

  logic [FW-1:0]      shReg, curFrame;
  logic [WIPER_W-1:0] w0Q, w1Q, nextW0, nextW1;
  logic               stkQ;

  always_comb begin
    curFrame = packFrame(w0Q, w1Q, stkQ);
    for (int k = 0; k < WIPER_W; k++) begin
      nextW1[WIPER_W-1-k] = shReg[1 + k];
      nextW0[WIPER_W-1-k] = shReg[WIPER_W + 1 + k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= packFrame(RESET_POS, RESET_POS, 1'b0);
    end else if (strb.shift) begin
      shReg <= {dataBit, shReg[FW-1:1]};
    end else if (strb.load) begin
      shReg <= curFrame;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      w0Q  <= RESET_POS;
      w1Q  <= RESET_POS;
      stkQ <= 1'b0;
    end else if (strb.commit) begin
      w0Q  <= nextW0;
      w1Q  <= nextW1;
      stkQ <= shReg[0];
    end
  end

  assign wiper0   = w0Q;
  assign wiper1   = w1Q;
  assign stackSel = stkQ;
  assign casOut   = strb.csActive & shReg[0];

  // R3
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable({w0Q, w1Q, stkQ}));

  // R6
  shift_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> shReg[FW-2:0] == $past(shReg[FW-1:1]));
endmodule

// File: rtl/pot3w_if.sv
module pot3w_if
  import pot3w_pkg::*;
#(
  parameter int WIPER_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csIn,
  input  logic               sclkIn,
  input  logic               sdIn,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic               stackSel,
  output logic               casOut
);
  ctlStrb_t strb;
  logic     dataBit;

  pot3w_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdIn(sdIn),
    .strb(strb), .dataBit(dataBit)
  );

  pot3w_dpath #(.WIPER_W(WIPER_W), .RESET_POS(WIPER_W'(1) << (WIPER_W - 1))) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .dataBit(dataBit),
    .wiper0(wiper0), .wiper1(wiper1), .stackSel(stackSel), .casOut(casOut)
  );
endmodule

// File: tb/sim_pot3w_if.sv
module sim_pot3w_if;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, csIn = 1'b0, sclkIn = 1'b0, sdIn = 1'b0;
  logic [7:0] wiper0, wiper1;
  logic stackSel, casOut;

  pot3w_if u0 (.clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdIn(sdIn),
               .wiper0(wiper0), .wiper1(wiper1), .stackSel(stackSel), .casOut(casOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vecs = 0, miss = 0;
  bit chain[$];
  logic [7:0] mW0 = 8'h80, mW1 = 8'h80;
  logic mStk = 1'b0;
  typedef struct { logic val; string req; } exp_t;
  exp_t expQ[$];
  event sampleEv;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    exp_t e;
    @(sampleEv);
    e = expQ.pop_front();
    check(e.req, {31'd0, casOut}, {31'd0, e.val});
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csStart();
    csIn = 1'b1;
    waitN(8);
    chain.delete();
    chain.push_back(mStk);
    for (int k = 7; k >= 0; k--) chain.push_back(mW1[k]);
    for (int k = 7; k >= 0; k--) chain.push_back(mW0[k]);
  endtask

  task automatic sendBit(bit b, string req);
    expQ.push_back('{chain[0], req});
    -> sampleEv;
    void'(chain.pop_front());
    chain.push_back(b);
    #1;
    sdIn = b;
    waitN(4);
    sclkIn = 1'b1;
    waitN(8);
    sclkIn = 1'b0;
    waitN(4);
  endtask

  task automatic csEnd();
    csIn = 1'b0;
    waitN(12);
    mStk = chain[0];
    for (int k = 0; k < 8; k++) begin
      mW1[7-k] = chain[1+k];
      mW0[7-k] = chain[9+k];
    end
  endtask

  task automatic sendFrame(bit stk, logic [7:0] w1, logic [7:0] w0, string req);
    sendBit(stk, req);
    for (int k = 7; k >= 0; k--) sendBit(w1[k], req);
    for (int k = 7; k >= 0; k--) sendBit(w0[k], req);
  endtask

  task automatic checkOuts(string req);
    check(req, {24'd0, wiper0}, {24'd0, mW0});
    check(req, {24'd0, wiper1}, {24'd0, mW1});
    check(req, {31'd0, stackSel}, {31'd0, mStk});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [7:0] s0, s1;
    logic sS;
    waitN(5);
    rstN = 1'b1;
    waitN(4);
    // R1 reset values
    check("R1", {24'd0, wiper0}, 32'h80);
    check("R1", {24'd0, wiper1}, 32'h80);
    check("R1", {31'd0, stackSel}, 0);
    check("R1", {31'd0, casOut}, 0);

    // R2 / R5: full frame, readback of reset values
    csStart();
    sendFrame(1'b1, 8'h3C, 8'hA5, "R5");
    csEnd();
    checkOuts("R2");
    check("R2", {24'd0, wiper1}, 32'h3C);
    check("R2", {24'd0, wiper0}, 32'hA5);
    check("R2", {31'd0, stackSel}, 1);

    // R3: outputs hold in mid-frame
    csStart();
    sendBit(1'b0, "R5");
    for (int k = 0; k < 8; k++) sendBit(1'b0, "R5");
    check("R3", {24'd0, wiper1}, 32'h3C);
    check("R3", {24'd0, wiper0}, 32'hA5);
    check("R3", {31'd0, stackSel}, 1);
    for (int k = 0; k < 8; k++) sendBit(1'b1, "R5");
    csEnd();
    checkOuts("R3");

    // R4 / R8: serial clock activity while deselected
    s0 = mW0; s1 = mW1; sS = mStk;
    for (int k = 0; k < 20; k++) begin
      sdIn = k[0] ^ k[2];
      waitN(3);
      sclkIn = 1'b1;
      waitN(5);
      check("R8", {31'd0, casOut}, 0);
      sclkIn = 1'b0;
      waitN(3);
    end
    check("R4", {24'd0, wiper0}, {24'd0, s0});
    check("R4", {24'd0, wiper1}, {24'd0, s1});
    check("R4", {31'd0, stackSel}, {31'd0, sS});
    // readback after idle noise must still be the settings (R4)
    csStart();
    sendFrame(1'b0, 8'hFF, 8'h00, "R4");
    csEnd();
    checkOuts("R2");

    // R7: select pulse without clocks
    s0 = mW0; s1 = mW1; sS = mStk;
    csStart();
    csEnd();
    check("R7", {24'd0, wiper0}, {24'd0, s0});
    check("R7", {24'd0, wiper1}, {24'd0, s1});
    check("R7", {31'd0, stackSel}, {31'd0, sS});

    // R6: 34 bits, first frame passes through on casOut
    csStart();
    sendFrame(1'b1, 8'h00, 8'hFF, "R5");
    sendFrame(1'b0, 8'h5A, 8'h81, "R6");
    csEnd();
    checkOuts("R6");
    check("R6", {24'd0, wiper1}, 32'h5A);

    // R9: short frame of 5 bits
    csStart();
    sendBit(1'b1, "R9");
    sendBit(1'b0, "R9");
    sendBit(1'b1, "R9");
    sendBit(1'b1, "R9");
    sendBit(1'b0, "R9");
    csEnd();
    checkOuts("R9");
    check("R8", {31'd0, casOut}, 0);

    waitN(4);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule